// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that gives an external bus controller write and read access to a bank of 8-bit registers held outside the block. A fast system clock oversamples SCL and SDA. The block never drives SCL. It drives SDA only through an open-drain enable, where a 1 pulls the wire low. Both bus wires pass through a two-stage synchronizer. START and STOP are decoded from the synchronized levels, so the system clock must run at least 20 times faster than the bus bit rate. Standard-mode and fast-mode bus rates are therefore well within range.

A write transaction has three bytes. The first is the 7-bit device address with R/W = 0. The second sets an 8-bit register pointer. The third is a data byte, which the block stores through a one-cycle write strobe carrying the pointer and the data. The pointer is kept across STOP, repeated START and aborted transfers. A later read therefore returns the register that the last write selected. A read is the address byte with R/W = 1. After it, the block shifts out the byte presented on `rd_data_i` for the pointer on `rd_addr_o`, MSB first. It repeats that byte for as long as the controller acknowledges.

The device address is a fixed five-bit prefix, binary 10010, followed by two strap inputs. With the straps at binary 11 the address is 0x4B. For example, writing 0x92 to register 0x6D sets that register to 0x92.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `wr_en_o` is 0 and the register pointer on `rd_addr_o` is 0x00.
- R2: A START (SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after a STOP and without a new START receive no ACK.
- R3: The first byte after a START is taken MSB first as seven address bits followed by R/W. The block acknowledges only when the address bits equal {10010, strap_i[1:0]}. On a mismatch it leaves SDA released for the rest of the transfer, up to the next START.
- R4: An ACK is `sda_oe_o` = 1 throughout the ninth SCL high period of a byte. `sda_oe_o` changes only while SCL is low.
- R5: In a write, the byte after the address sets the register pointer. The byte after that produces exactly one single-cycle `wr_en_o` pulse, with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte. Both of these bytes are acknowledged.
- R6: For an address with R/W = 1, the block drives `rd_data_i` for the pointer register MSB first, starting at the SCL falling edge that ends the address ACK. The SDA wire is low for a 0 bit and released for a 1 bit.
- R7: During a read, a controller ACK (SDA low in the ninth clock) makes the block send the same register again. A controller NACK makes it release SDA until the next START or STOP.
- R8: The register pointer is kept across STOP and repeated START. A read issued after a write returns the register that the write addressed.
- R9: A STOP or START that arrives in the middle of a byte aborts the transfer. No write strobe is issued and the pointer keeps its value.
- R10: Data bytes after the first one in a write transaction are not acknowledged and cause no write strobe.
- R11: A repeated START right after a write's data ACK, with no STOP between them, begins a new transaction that is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| strap_i | input | 2 | Low two bits of the device address |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 8 | Register address for the write strobe |
| wr_data_o | output | 8 | Register data for the write strobe |
| rd_addr_o | output | 8 | Register pointer presented to the bank for reads |
| rd_data_i | input | 8 | Bank read data for `rd_addr_o` |

## Verification
The bench covers several failure modes in turn:
- Transfers aborted in mid-byte, by STOP or by an unexpected START. A design that treats a partial byte as complete issues a spurious strobe, and the scoreboard sees an unexpected write.
- A design that clears the pointer on STOP or START. It would read back register 0x00 instead of the register last addressed.
- Reads after a wrong address and after a strap change. A design that ignores the strap pins, or that acknowledges a mismatched address, fails the ACK checks.
- Bytes sent with no START, and a second data byte in one write. Mishandling either one shows up as a false ACK or an extra strobe.
- Several acknowledged reads in a row. A design that drops or shifts a bit on the reload returns a corrupted value.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e             state;
        tgt_state_e             after_ack;
        logic [BIT_CNT_W-1:0]   bit_cnt;
        logic [BYTE_W-1:0]      shreg;
        logic [BYTE_W-1:0]      ptr;
        logic                   byte_done;
        logic                   give_ack;
        logic                   ctrl_ack;
        logic                   oe;
        logic                   wen;
        logic [BYTE_W-1:0]      wdata;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '1;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '1;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign lvl  = stage_q[STAGES-1];
    assign rise = stage_q[STAGES-1] & ~prev_q;
    assign fall = ~stage_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int               STRAP_W = 2,
    parameter int               ADDR_W  = 7,
    parameter logic [ADDR_W-STRAP_W-1:0] PREFIX = 5'b10010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_lvl,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               wen,
    output logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  ptr
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    tgt_regs_t r_q, r_d;
    logic [BYTE_W-1:0] byte_in;
    logic [ADDR_W-1:0] dev_addr;

    assign byte_in  = {r_q.shreg[BYTE_W-2:0], sda_lvl};
    assign dev_addr = {PREFIX, strap};

    always_comb begin
        r_d     = r_q;
        r_d.wen = 1'b0;
        if (start_det) begin
            r_d.state     = ST_ADDR;
            r_d.bit_cnt   = '0;
            r_d.byte_done = 1'b0;
            r_d.oe        = 1'b0;
        end else if (stop_det) begin
            r_d.state     = ST_IDLE;
            r_d.bit_cnt   = '0;
            r_d.byte_done = 1'b0;
            r_d.oe        = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_REG, ST_WDATA: begin
                    if (scl_rise && !r_q.byte_done) begin
                        r_d.shreg   = byte_in;
                        r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                        if (r_q.bit_cnt == LAST_BIT) begin
                            r_d.byte_done = 1'b1;
                            if (r_q.state == ST_ADDR) begin
                                r_d.give_ack  = (byte_in[BYTE_W-1:1] == dev_addr);
                                r_d.after_ack = byte_in[0] ? ST_RDATA : ST_REG;
                            end else if (r_q.state == ST_REG) begin
                                r_d.give_ack  = 1'b1;
                                r_d.ptr       = byte_in;
                                r_d.after_ack = ST_WDATA;
                            end else begin
                                r_d.give_ack  = 1'b1;
                                r_d.wen       = 1'b1;
                                r_d.wdata     = byte_in;
                                r_d.after_ack = ST_IGNORE;
                            end
                        end
                    end else if (scl_fall && r_q.byte_done) begin
                        r_d.byte_done = 1'b0;
                        r_d.bit_cnt   = '0;
                        if (r_q.give_ack) begin
                            r_d.state = ST_ACK;
                            r_d.oe    = 1'b1;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.state = r_q.after_ack;
                        r_d.oe    = 1'b0;
                        if (r_q.after_ack == ST_RDATA) begin
                            r_d.shreg   = rd_data;
                            r_d.oe      = ~rd_data[BYTE_W-1];
                            r_d.bit_cnt = '0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (r_q.bit_cnt == LAST_BIT) begin
                            r_d.state   = ST_MACK;
                            r_d.oe      = 1'b0;
                            r_d.bit_cnt = '0;
                        end else begin
                            r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                            r_d.shreg   = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.oe      = ~r_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.ctrl_ack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.ctrl_ack) begin
                            r_d.state   = ST_RDATA;
                            r_d.shreg   = rd_data;
                            r_d.oe      = ~rd_data[BYTE_W-1];
                            r_d.bit_cnt = '0;
                        end else begin
                            r_d.state = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= ST_IDLE;
            r_q.after_ack <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe = r_q.oe;
    assign wen    = r_q.wen;
    assign wdata  = r_q.wdata;
    assign ptr    = r_q.ptr;

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int STRAP_W     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o,
    output logic               wr_en_o,
    output logic [BYTE_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic [BYTE_W-1:0]  rd_addr_o,
    input  logic [BYTE_W-1:0]  rd_data_i
);

    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [1:0] bus_lvl, bus_rise, bus_fall;
    logic       scl_lvl, start_det, stop_det;
    logic [BYTE_W-1:0] ptr;

    i2c_tgt_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({scl_i, sda_i}),
        .lvl   (bus_lvl),
        .rise  (bus_rise),
        .fall  (bus_fall)
    );

    assign scl_lvl   = bus_lvl[IDX_SCL];
    assign start_det = bus_fall[IDX_SDA] & scl_lvl;
    assign stop_det  = bus_rise[IDX_SDA] & scl_lvl;

    i2c_tgt_engine #(
        .STRAP_W (STRAP_W),
        .ADDR_W  (7),
        .PREFIX  (5'b10010)
    ) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (bus_rise[IDX_SCL]),
        .scl_fall  (bus_fall[IDX_SCL]),
        .sda_lvl   (bus_lvl[IDX_SDA]),
        .strap     (strap_i),
        .rd_data   (rd_data_i),
        .sda_oe    (sda_oe_o),
        .wen       (wr_en_o),
        .wdata     (wr_data_o),
        .ptr       (ptr)
    );

    assign wr_addr_o = ptr;
    assign rd_addr_o = ptr;

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_lvl,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe_o,
    input logic wr_en_o
);

    // R4: the open-drain enable moves only while the synchronized SCL is low
    a_r4_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_lvl);

    // R2: a STOP leaves SDA released
    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R9: a START never coincides with a write strobe in the next cycle
    a_r9_start_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !wr_en_o);

    // R5: the write strobe lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R5: the strobe follows a sampling edge, so SCL is high
    a_r5_strobe_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> scl_lvl);

endmodule

bind i2c_reg_target i2c_reg_target_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en_o)
);

// File: tb/i2c_reg_target_tb_top.sv
module i2c_reg_target_tb_top;

    localparam int Q        = 40;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] strap = 2'b11;
    logic       sda_line;
    logic       sda_oe_o, wr_en_o;
    logic [7:0] wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;

    logic [7:0] bank    [256];
    logic [7:0] ref_mem [256];
    logic [15:0] exp_q [$];
    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = ~(m_low | sda_oe_o);
    assign rd_data_i = bank[rd_addr_o];

    i2c_reg_target dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i)
    );

    always @(posedge clk) if (wr_en_o) bank[wr_addr_o] <= wr_data_o;

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // monitor: every strobe must match the next expected write
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            vectors++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5/R9/R10: actual write 0x%0h<=0x%0h expected none",
                         wr_addr_o, wr_data_o);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if ({wr_addr_o, wr_data_o} != e) begin
                    errors++;
                    $display("FAIL R5: actual write 0x%0h expected 0x%0h",
                             {wr_addr_o, wr_data_o}, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; tick(Q);
            m_scl = 1'b1;  tick(2 * Q);
            m_scl = 1'b0;  tick(Q);
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = (sda_line == 1'b0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic read_byte(output logic [7:0] b, input logic give_ack);
        m_low = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_low = give_ack; tick(Q);
        m_scl = 1'b1;     tick(2 * Q);
        m_scl = 1'b0;     tick(Q);
        m_low = 1'b0;
    endtask

    task automatic full_write(input logic [6:0] dev, input logic [7:0] ra,
                              input logic [7:0] d, input string req);
        logic a;
        exp_q.push_back({ra, d});
        ref_mem[ra] = d;
        bus_start();
        write_byte({dev, 1'b0}, a); check({req, " addr ack"}, a, 1);
        write_byte(ra, a);          check({req, " reg ack"}, a, 1);
        write_byte(d, a);           check({req, " data ack"}, a, 1);
    endtask

    task automatic read_check(input logic [6:0] dev, input logic [7:0] ra,
                              input int count, input string req);
        logic a;
        logic [7:0] v;
        bus_start();
        write_byte({dev, 1'b1}, a); check({req, " read addr ack"}, a, 1);
        for (int k = 0; k < count; k++) begin
            read_byte(v, k != count - 1);
            check({req, " read data"}, v, ref_mem[ra]);
        end
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < 256; i++) begin
            bank[i]    = '0;
            ref_mem[i] = '0;
        end
        tick(5);
        // R1: reset state
        check("R1 oe", sda_oe_o, 0);
        check("R1 wen", wr_en_o, 0);
        check("R1 ptr", rd_addr_o, 0);
        rst_n = 1'b1;
        tick(Q);

        // R3 R5: 0x92 to register 0x6D via address 0x4B
        full_write(7'h4B, 8'h6D, 8'h92, "R5");
        // R11: repeated START straight after the data ACK
        full_write(7'h4B, 8'h21, 8'h5A, "R11");
        bus_stop();
        check("R5 bank 0x6D", bank[8'h6D], 8'h92);
        check("R5 pointer", rd_addr_o, 8'h21);

        // R8 R6: set pointer to 0x6D, read back after repeated START
        full_write(7'h4B, 8'h6D, 8'h92, "R8");
        read_check(7'h4B, 8'h6D, 1, "R8 R6");
        bus_stop();
        // R7: three reads of the same register, last one NACKed
        read_check(7'h4B, 8'h6D, 3, "R7");
        bus_stop();
        check("R7 released", sda_oe_o, 0);

        // R3: wrong address ignored, following bytes not acknowledged
        bus_start();
        write_byte({7'h4A, 1'b0}, a); check("R3 mismatch nack", a, 0);
        write_byte(8'h6D, a);         check("R3 ignored reg nack", a, 0);
        write_byte(8'h00, a);         check("R3 ignored data nack", a, 0);
        bus_stop();
        check("R3 bank kept", bank[8'h6D], 8'h92);

        // R3: strap change
        strap = 2'b01;
        bus_start();
        write_byte({7'h4B, 1'b0}, a); check("R3 old addr nack", a, 0);
        bus_stop();
        full_write(7'h49, 8'h30, 8'hC3, "R3 strap 01");
        bus_stop();
        strap = 2'b11;

        // R2: byte without START after STOP is ignored
        send_bits({7'h4B, 1'b0}, 8);
        m_low = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
        check("R2 no ack without start", sda_line, 1);
        tick(Q); m_scl = 1'b0; tick(Q);
        bus_stop();

        // R9: STOP in the middle of a data byte
        bus_start();
        write_byte({7'h4B, 1'b0}, a); check("R9 addr ack", a, 1);
        write_byte(8'h21, a);         check("R9 reg ack", a, 1);
        send_bits(8'hFF, 4);
        bus_stop();
        check("R9 bank kept after stop", bank[8'h21], 8'h5A);
        read_check(7'h4B, 8'h21, 1, "R9 pointer after stop");
        bus_stop();

        // R9: START in the middle of a data byte
        bus_start();
        write_byte({7'h4B, 1'b0}, a);
        write_byte(8'h30, a);
        send_bits(8'h00, 5);
        read_check(7'h4B, 8'h30, 1, "R9 pointer after start");
        bus_stop();

        // R10: second data byte in one write
        full_write(7'h4B, 8'h40, 8'h11, "R10");
        write_byte(8'h22, a); check("R10 extra byte nack", a, 0);
        bus_stop();
        check("R10 bank", bank[8'h40], 8'h11);
        read_check(7'h4B, 8'h40, 2, "R10 read");
        bus_stop();

        tick(4 * Q);
        check("R5 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule